// File: doc/BRIEF.md
# Fine-Rate Time-of-Day Counter

This block keeps a seconds and nanoseconds time of day for stamping packets. Its rate is trimmed by a fractional accumulator. On every system clock a 32-bit rate word is added into a 32-bit accumulator. Each carry out of that sum moves the nanoseconds forward by a programmable sub-second step. When the nanoseconds reach one billion they wrap and the seconds count up. A rate word of about 2^32 × (1/step_ns) / f_clk_GHz therefore makes the counter run at true speed. For example, with a 20 ns step the rate word is (50 MHz × 2^32) / f_clk.

Software controls the counter with single-cycle command pulses. One loads the time outright. One steps the time forward or backward by an update value; bit 31 of the update nanoseconds word picks subtraction. One latches a newly presented rate word. One arms a target time, and reaching that time sets a sticky alarm flag. The alarm interrupt is masked when the armed target is zero. Reading the alarm clears it.

Top module: `tod_timer_top`

## Requirements
- R1: After reset the time reads 0 s / 0 ns, the alarm flag and interrupt are 0, and the rate word is 0, so the time stays frozen until a rate word is loaded.
- R2: Each clock adds the active rate word to the accumulator. On a carry out, the nanoseconds advance by `subsec_inc`, so a rate word of 0x8000_0000 gives one step every 2 clocks and 0x4000_0000 gives one step every 4 clocks.
- R3: When a step takes the nanoseconds to 1,000,000,000 or more, they wrap by that amount and the seconds increase by one.
- R4: An `cmd_init` pulse loads `upd_sec` and `upd_ns[29:0]` into the time on the next clock edge. It takes priority over a simultaneous `cmd_step` and over a rate step.
- R5: A `cmd_step` pulse with `upd_ns[31]` = 0 adds `upd_sec`/`upd_ns[29:0]` to the time, with the nanosecond carry going into the seconds.
- R6: A `cmd_step` pulse with `upd_ns[31]` = 1 subtracts `upd_sec`/`upd_ns[29:0]` from the time. A nanosecond borrow adds 1,000,000,000 to the nanoseconds and takes one more second away.
- R7: A value on `addend_val` has no effect until `addend_load` is pulsed. From the clock after the load it becomes the active rate word.
- R8: A `tgt_load` pulse stores the target and arms the alarm. The flag goes to 1 on the clock edge after the time is first at or past the target. The alarm then disarms, so it fires once per arming.
- R9: An `alarm_rd` pulse clears the alarm flag. If a set and a clear fall on the same edge, the set wins.
- R10: `alarm_irq` follows the alarm flag when the armed target was nonzero. It stays 0 when the armed target was 0 s / 0 ns.
- R11: The nanoseconds output never reaches 1,000,000,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addend_val | input | 32 | Rate word presented for loading |
| addend_load | input | 1 | Pulse: latch `addend_val` as the active rate word |
| subsec_inc | input | 8 | Nanoseconds added per accumulator carry |
| upd_sec | input | 32 | Update seconds for load or step |
| upd_ns | input | 32 | Update nanoseconds in [29:0]; bit 31 selects subtract on step |
| cmd_init | input | 1 | Pulse: load the update value as the time |
| cmd_step | input | 1 | Pulse: add or subtract the update value |
| tgt_sec | input | 32 | Target seconds |
| tgt_ns | input | 30 | Target nanoseconds |
| tgt_load | input | 1 | Pulse: store the target and arm the alarm |
| alarm_rd | input | 1 | Pulse: read-clear of the alarm flag |
| tod_sec | output | 32 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |
| alarm_flag | output | 1 | Sticky alarm status |
| alarm_irq | output | 1 | Alarm interrupt, masked for a zero target |

## Verification
The range property on nanoseconds assumes that every loaded or stepped `upd_ns[29:0]` value is below one billion and that `subsec_inc` is well under one billion. The bench only drives such values. The frozen-time property assumes that commands arrive only as single-cycle pulses, so the bench raises each command for exactly one clock. Target nanoseconds are also kept below one billion so that every target can be reached.

// File: rtl/tod_pkg.sv
// Shared widths and constants for the time-of-day counter.
// Assumes nanoseconds are held in 30 bits (one billion fits below 2^30).
package tod_pkg;
    localparam int NS_W     = 30;
    localparam int NS_WIDE  = NS_W + 1;
    localparam logic [NS_WIDE-1:0] NS_PER_SEC = NS_WIDE'(1_000_000_000);
endpackage

// File: rtl/tod_rate_accum.sv
// Fractional rate accumulator: adds the active rate word every clock and
// emits a one-cycle step request on each carry out.
// Assumes addend_load is a single-cycle pulse; a loaded word is used from
// the following clock. The accumulator phase is kept across loads.
module tod_rate_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] addend_val,
    input  logic             addend_load,
    output logic             step_req
);
    logic [ACC_W-1:0] addend_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    // Wide sum of accumulator and active rate word.
    always_comb sum = {1'b0, acc_q} + {1'b0, addend_q};

    assign step_req = sum[ACC_W];

    // Hold the accumulator and the active rate word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addend_q <= '0;
            acc_q    <= '0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
            if (addend_load) addend_q <= addend_val;
        end
    end

    // R7
    new_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addend_load |=> (addend_q == $past(addend_val)));
endmodule

// File: rtl/tod_time_core.sv
// Seconds/nanoseconds register with load, signed step and rate stepping.
// Priority: load over step over rate step. Assumes update nanoseconds and
// the sub-second increment are below one billion.
module tod_time_core
    import tod_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_req,
    input  logic [INC_W-1:0] subsec_inc,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [31:0]      upd_ns,
    input  logic             cmd_init,
    input  logic             cmd_step,
    output logic [SEC_W-1:0] sec_q,
    output logic [NS_W-1:0]  ns_q
);
    logic [NS_WIDE-1:0] upd_mag;
    logic               do_sub;
    logic [NS_WIDE-1:0] add_ns, sub_ns, tick_ns;
    logic [SEC_W-1:0]   sec_d;
    logic [NS_WIDE-1:0] ns_d;

    assign upd_mag = {1'b0, upd_ns[NS_W-1:0]};
    assign do_sub  = upd_ns[31];

    // Candidate next times for every kind of update.
    always_comb begin
        add_ns  = {1'b0, ns_q} + upd_mag;
        sub_ns  = {1'b0, ns_q} - upd_mag;
        tick_ns = {1'b0, ns_q} + NS_WIDE'(subsec_inc);
        sec_d   = sec_q;
        ns_d    = {1'b0, ns_q};
        if (cmd_init) begin
            sec_d = upd_sec;
            ns_d  = upd_mag;
        end else if (cmd_step && !do_sub) begin
            if (add_ns >= NS_PER_SEC) begin
                ns_d  = add_ns - NS_PER_SEC;
                sec_d = sec_q + upd_sec + SEC_W'(1);
            end else begin
                ns_d  = add_ns;
                sec_d = sec_q + upd_sec;
            end
        end else if (cmd_step) begin
            if (sub_ns[NS_W]) begin
                ns_d  = sub_ns + NS_PER_SEC;
                sec_d = sec_q - upd_sec - SEC_W'(1);
            end else begin
                ns_d  = sub_ns;
                sec_d = sec_q - upd_sec;
            end
        end else if (step_req) begin
            if (tick_ns >= NS_PER_SEC) begin
                ns_d  = tick_ns - NS_PER_SEC;
                sec_d = sec_q + SEC_W'(1);
            end else begin
                ns_d = tick_ns;
            end
        end
    end

    // Time registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else begin
            sec_q <= sec_d;
            ns_q  <= ns_d[NS_W-1:0];
        end
    end

    // R11
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, ns_q} < NS_PER_SEC));

    // R2
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_req && !cmd_init && !cmd_step) |=> ($stable(ns_q) && $stable(sec_q)));

    // R4
    init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_init |=> (sec_q == $past(upd_sec)) && (ns_q == $past(upd_ns[NS_W-1:0])));
endmodule

// File: rtl/tod_alarm.sv
// Target-time alarm: arms on a target load, sets a sticky flag one clock
// after the time is at or past the target, then disarms. Read clears the
// flag; set wins over clear. Interrupt masked for a zero target.
module tod_alarm
    import tod_pkg::*;
#(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] cur_sec,
    input  logic [NS_W-1:0]  cur_ns,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [NS_W-1:0]  tgt_ns,
    input  logic             tgt_load,
    input  logic             alarm_rd,
    output logic             alarm_flag,
    output logic             alarm_irq
);
    logic [SEC_W-1:0] tsec_q;
    logic [NS_W-1:0]  tns_q;
    logic             armed_q, irq_en_q, reached;

    // Compare current time against the stored target.
    always_comb reached = (cur_sec > tsec_q) ||
                          ((cur_sec == tsec_q) && (cur_ns >= tns_q));

    // Target storage, arming and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsec_q     <= '0;
            tns_q      <= '0;
            armed_q    <= 1'b0;
            irq_en_q   <= 1'b0;
            alarm_flag <= 1'b0;
        end else begin
            if (tgt_load) begin
                tsec_q   <= tgt_sec;
                tns_q    <= tgt_ns;
                armed_q  <= 1'b1;
                irq_en_q <= (tgt_sec != '0) || (tgt_ns != '0);
            end else if (armed_q && reached) begin
                armed_q <= 1'b0;
            end
            if (!tgt_load && armed_q && reached) alarm_flag <= 1'b1;
            else if (alarm_rd)                   alarm_flag <= 1'b0;
        end
    end

    assign alarm_irq = alarm_flag & irq_en_q;

    // R10
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_flag);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> $past(alarm_rd));
endmodule

// File: rtl/tod_timer_top.sv
// Time-of-day counter top: rate accumulator feeding the time core, with
// the target alarm watching the time. Commands are single-cycle pulses.
module tod_timer_top
    import tod_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int INC_W = 8,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] addend_val,
    input  logic             addend_load,
    input  logic [INC_W-1:0] subsec_inc,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [31:0]      upd_ns,
    input  logic             cmd_init,
    input  logic             cmd_step,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [NS_W-1:0]  tgt_ns,
    input  logic             tgt_load,
    input  logic             alarm_rd,
    output logic [SEC_W-1:0] tod_sec,
    output logic [NS_W-1:0]  tod_ns,
    output logic             alarm_flag,
    output logic             alarm_irq
);
    logic step_req;

    tod_rate_accum #(.ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .addend_val(addend_val),
        .addend_load(addend_load), .step_req(step_req)
    );

    tod_time_core #(.SEC_W(SEC_W), .INC_W(INC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .step_req(step_req), .subsec_inc(subsec_inc),
        .upd_sec(upd_sec), .upd_ns(upd_ns), .cmd_init(cmd_init),
        .cmd_step(cmd_step), .sec_q(tod_sec), .ns_q(tod_ns)
    );

    tod_alarm #(.SEC_W(SEC_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .cur_sec(tod_sec), .cur_ns(tod_ns),
        .tgt_sec(tgt_sec), .tgt_ns(tgt_ns), .tgt_load(tgt_load),
        .alarm_rd(alarm_rd), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );
endmodule

// File: tb/tb_tod_timer_top.sv
`timescale 1ns/1ps
module tb_tod_timer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addend_val = '0;
    logic        addend_load = 1'b0;
    logic [7:0]  subsec_inc = '0;
    logic [31:0] upd_sec = '0;
    logic [31:0] upd_ns = '0;
    logic        cmd_init = 1'b0, cmd_step = 1'b0;
    logic [31:0] tgt_sec = '0;
    logic [29:0] tgt_ns = '0;
    logic        tgt_load = 1'b0, alarm_rd = 1'b0;
    logic [31:0] tod_sec;
    logic [29:0] tod_ns;
    logic        alarm_flag, alarm_irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tod_timer_top dut (
        .clk(clk), .rst_n(rst_n), .addend_val(addend_val), .addend_load(addend_load),
        .subsec_inc(subsec_inc), .upd_sec(upd_sec), .upd_ns(upd_ns),
        .cmd_init(cmd_init), .cmd_step(cmd_step), .tgt_sec(tgt_sec), .tgt_ns(tgt_ns),
        .tgt_load(tgt_load), .alarm_rd(alarm_rd), .tod_sec(tod_sec), .tod_ns(tod_ns),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_time(input string req, input longint s, input longint ns);
        check(req, tod_sec, s);
        check(req, tod_ns, ns);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_init(input logic [31:0] s, input logic [31:0] ns);
        upd_sec = s; upd_ns = ns; cmd_init = 1'b1;
        @(negedge clk); cmd_init = 1'b0;
    endtask

    task automatic do_step(input logic [31:0] s, input logic [31:0] ns);
        upd_sec = s; upd_ns = ns; cmd_step = 1'b1;
        @(negedge clk); cmd_step = 1'b0;
    endtask

    task automatic load_rate(input logic [31:0] a);
        addend_val = a; addend_load = 1'b1;
        @(negedge clk); addend_load = 1'b0;
    endtask

    task automatic load_target(input logic [31:0] s, input logic [29:0] ns);
        tgt_sec = s; tgt_ns = ns; tgt_load = 1'b1;
        @(negedge clk); tgt_load = 1'b0;
    endtask

    task automatic t_reset;
        cycles(3); rst_n = 1'b1;
        check_time("R1 reset time", 0, 0);
        check("R1 reset flag", alarm_flag, 0);
        check("R1 reset irq", alarm_irq, 0);
        cycles(5);
        check_time("R1 frozen at zero rate", 0, 0);
    endtask

    task automatic t_init;
        do_init(5, 999_999_990);
        check_time("R4 init load", 5, 999_999_990);
        upd_sec = 9; upd_ns = 7; cmd_init = 1'b1; cmd_step = 1'b1;
        @(negedge clk); cmd_init = 1'b0; cmd_step = 1'b0;
        check_time("R4 init beats step", 9, 7);
    endtask

    task automatic t_step;
        do_init(5, 999_999_990);
        do_step(1, 20);
        check_time("R5 add with carry", 7, 10);
        do_step(2, 32'h8000_0000 | 30);
        check_time("R6 subtract with borrow", 4, 999_999_980);
        do_step(0, 32'h8000_0000 | 5);
        check_time("R6 subtract no borrow", 4, 999_999_975);
    endtask

    task automatic t_rate;
        subsec_inc = 8'd20;
        load_rate(32'h8000_0000);
        do_init(0, 999_999_960);
        cycles(2);
        check_time("R2 half rate one step", 0, 999_999_980);
        cycles(2);
        check_time("R3 rollover to seconds", 1, 0);
        cycles(4);
        check_time("R2 two more steps", 1, 40);
        subsec_inc = 8'd10;
        load_rate(32'h4000_0000);
        do_init(0, 0);
        cycles(8);
        check_time("R2 quarter rate", 0, 20);
    endtask

    task automatic t_no_load;
        load_rate(32'h0);
        addend_val = 32'h8000_0000;
        do_init(0, 0);
        cycles(6);
        check_time("R7 unloaded rate ignored", 0, 0);
        addend_val = 32'h0;
    endtask

    task automatic t_alarm;
        do_init(3, 100);
        load_target(3, 200);
        cycles(3);
        check("R8 not yet reached", alarm_flag, 0);
        do_step(0, 100);
        check("R8 one cycle latency", alarm_flag, 0);
        @(negedge clk);
        check("R8 flag set", alarm_flag, 1);
        check("R10 irq nonzero target", alarm_irq, 1);
        alarm_rd = 1'b1; @(negedge clk); alarm_rd = 1'b0;
        check("R9 read clears", alarm_flag, 0);
        cycles(3);
        check("R8 fires once per arming", alarm_flag, 0);
        load_target(3, 150);
        alarm_rd = 1'b1; @(negedge clk); alarm_rd = 1'b0;
        check("R9 set beats clear", alarm_flag, 1);
        alarm_rd = 1'b1; @(negedge clk); alarm_rd = 1'b0;
        check("R9 clear after", alarm_flag, 0);
        load_target(0, 0);
        cycles(2);
        check("R10 zero target flag", alarm_flag, 1);
        check("R10 zero target irq masked", alarm_irq, 0);
    endtask

    initial begin
        t_reset();
        t_init();
        t_step();
        t_rate();
        t_no_load();
        t_alarm();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule